// File: doc/BRIEF.md
# Set/Clear GPIO Register Block

This block holds the per-pin control state for a 32-pin general-purpose I/O port and turns that state into pad control signals. The pins are split into banks of 16. Each bank owns six feature registers: output level, drive enable, open-drain mode, pull-up, pull-down and input enable. A bank's register set sits at a fixed stride in a 256-byte window. Pins 0-15 start at offset 0x00, and pins 16-31 start at 0x80, so address bit 7 selects the bank.

Every feature register is written with a paired word. A 1 in data bit n (0-15) turns the feature on for bank pin n. A 1 in data bit n+16 turns it off. Pins whose two bits are both 0 keep their state. Software can therefore change one pin without first reading the register, and two agents that write different pins cannot overwrite each other.

Reads return the per-pin state of one register. The output level is read back at its own offset, not at the offset used to write it. Each pad input passes through a two-flop synchronizer, and the result is gated by input enable.

Top module: `gpio_atomic_block`

## Requirements
- R1: After reset, every feature register reads 0. No pad is driven, no pull is enabled, in_sample is 0 and rd_data is 0.
- R2: A write with data bit n (n in 0..15) at 1 and bit n+16 at 0 turns the addressed feature on for pin n of the addressed bank. The change is visible from the cycle after the write.
- R3: A write with data bit n+16 at 1 turns the feature off for pin n. If bits n and n+16 are both 1, the feature ends up off.
- R4: A write leaves the state of a pin unchanged when both of its bits are 0. A write never changes other feature registers or the other bank.
- R5: Address bit 7 selects the bank. Offsets 0x00-0x7F serve pins 0-15, and the same offsets plus 0x80 serve pins 16-31. Register bit k of the high bank is pin 16+k.
- R6: The bank-relative offsets are: output level write 0x00, drive enable 0x04, open-drain 0x08, pull-up 0x18, pull-down 0x1C, input enable 0x20, output level readback 0x30. A read returns the state of the bank's 16 pins in rd_data bits 15:0, with bits 31:16 at 0. rd_data is loaded on the clock edge where rd_en is 1 and holds its value otherwise.
- R7: The output level is read at 0x30. A read at 0x00 returns 0, and a write at 0x30 has no effect.
- R8: A write to any other offset in the window has no effect, and a read from one returns 0. Offsets with address bits 1:0 not at 0 count as other offsets.
- R9: pad_drv_en of a pin is drive enable AND (NOT open-drain OR NOT output level). pad_drv_val is output level AND NOT open-drain. A pin whose drive enable is 0 is never driven. An open-drain pin is never driven high.
- R10: pad_pu_en and pad_pd_en follow the pull-up and pull-down registers pin for pin.
- R11: in_sample of a pin equals pad_in as sampled two clock edges earlier when input enable is 1, and is 0 when input enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte offset in the register window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write word: bits 15:0 turn features on, bits 31:16 turn them off |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read result, valid the cycle after rd_en |
| pad_in | input | 32 | Raw pad levels, asynchronous |
| pad_drv_en | output | 32 | Pad driver enable per pin |
| pad_drv_val | output | 32 | Pad driver level per pin |
| pad_pu_en | output | 32 | Pull-up enable per pin |
| pad_pd_en | output | 32 | Pull-down enable per pin |
| in_sample | output | 32 | Synchronized, enable-gated input level |

## Verification
Directed writes come first. They use words with only set bits, only clear bits, both bits for the same pins, and an all-zero word. These patterns tell turn-on, turn-off, clear priority and hold apart, and each one is done in both banks to expose bank-select errors. Writes to unmapped offsets and to the readback offset, and reads at the write-only offset, show whether decoding leaks. Seeded random writes over all offsets then mix overlapping set and clear masks, with reads and pad checks after each write. Open-drain and drive-enable combinations are checked at the pad outputs, and a pad-input step is sampled edge by edge to show the two-stage delay.

// File: rtl/gpio_atomic_pkg.sv
package gpio_atomic_pkg;

   localparam int NUM_FEAT = 6;
   localparam int FI_OUT = 0;
   localparam int FI_OE  = 1;
   localparam int FI_OD  = 2;
   localparam int FI_PU  = 3;
   localparam int FI_PD  = 4;
   localparam int FI_IE  = 5;

   localparam logic [7:0] OFS_OUT_WR = 8'h00;
   localparam logic [7:0] OFS_OE     = 8'h04;
   localparam logic [7:0] OFS_OD     = 8'h08;
   localparam logic [7:0] OFS_PU     = 8'h18;
   localparam logic [7:0] OFS_PD     = 8'h1C;
   localparam logic [7:0] OFS_IE     = 8'h20;
   localparam logic [7:0] OFS_OUT_RD = 8'h30;

   // one-hot feature select for a write at a bank-relative offset
   function automatic logic [NUM_FEAT-1:0] wr_decode(input logic [7:0] ofs);
      logic [NUM_FEAT-1:0] s;
      s = '0;
      case (ofs)
         OFS_OUT_WR: s[FI_OUT] = 1'b1;
         OFS_OE:     s[FI_OE]  = 1'b1;
         OFS_OD:     s[FI_OD]  = 1'b1;
         OFS_PU:     s[FI_PU]  = 1'b1;
         OFS_PD:     s[FI_PD]  = 1'b1;
         OFS_IE:     s[FI_IE]  = 1'b1;
         default:    s = '0;
      endcase
      return s;
   endfunction

   // one-hot feature select for a read; output level has its own offset
   function automatic logic [NUM_FEAT-1:0] rd_decode(input logic [7:0] ofs);
      logic [NUM_FEAT-1:0] s;
      s = '0;
      case (ofs)
         OFS_OUT_RD: s[FI_OUT] = 1'b1;
         OFS_OE:     s[FI_OE]  = 1'b1;
         OFS_OD:     s[FI_OD]  = 1'b1;
         OFS_PU:     s[FI_PU]  = 1'b1;
         OFS_PD:     s[FI_PD]  = 1'b1;
         OFS_IE:     s[FI_IE]  = 1'b1;
         default:    s = '0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/gpio_atomic_decode.sv
module gpio_atomic_decode
   import gpio_atomic_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int BANK_STRIDE = 128,
   parameter int NUM_BANKS   = 2
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_BANKS-1:0] bank_hit,
   output logic [NUM_FEAT-1:0]  wr_sel,
   output logic [NUM_FEAT-1:0]  rd_sel
);
   localparam int SEL_LSB = $clog2(BANK_STRIDE);
   localparam int SEL_W   = ADDR_W - SEL_LSB;

   generate
      if (SEL_W < 1)
         $error("address too narrow for bank select");
      if (SEL_LSB > 8 || SEL_LSB < 6)
         $error("bank stride must lie between 64 and 256 bytes");
   endgenerate

   logic [7:0]       ofs;
   logic [SEL_W-1:0] bank_idx;

   assign ofs      = 8'(addr[SEL_LSB-1:0]);
   assign bank_idx = addr[ADDR_W-1:SEL_LSB];
   assign wr_sel   = wr_decode(ofs);
   assign rd_sel   = rd_decode(ofs);

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
         assign bank_hit[b] = (bank_idx == SEL_W'(b));
      end
   endgenerate

endmodule

// File: rtl/gpio_atomic_bank.sv
module gpio_atomic_bank
   import gpio_atomic_pkg::*;
#(
   parameter int BANK_W = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [NUM_FEAT-1:0]              wr_sel,
   input  logic [BANK_W-1:0]                set_bits,
   input  logic [BANK_W-1:0]                clr_bits,
   output logic [NUM_FEAT-1:0][BANK_W-1:0]  feat_q
);

   generate
      for (genvar f = 0; f < NUM_FEAT; f++) begin : g_feat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               feat_q[f] <= '0;
            else if (wr_en && wr_sel[f])
               feat_q[f] <= (feat_q[f] | set_bits) & ~clr_bits;
         end

         AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel[f]) |=> ((feat_q[f] & $past(set_bits & ~clr_bits))
                                      == $past(set_bits & ~clr_bits))); // R2
         AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel[f]) |=> ((feat_q[f] & $past(clr_bits)) == '0)); // R3
         AST_UNTOUCHED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel[f]) |=> (((feat_q[f] ^ $past(feat_q[f]))
                                      & ~$past(set_bits | clr_bits)) == '0)); // R4
         AST_UNSELECTED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_sel[f]) |=> $stable(feat_q[f])); // R4
      end
   endgenerate

endmodule

// File: rtl/gpio_atomic_sync.sv
module gpio_atomic_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2)
         $error("synchronizer needs at least two stages");
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chain[0] <= '0;
      else
         chain[0] <= d;
   end

   generate
      for (genvar k = 1; k < STAGES; k++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chain[k] <= '0;
            else
               chain[k] <= chain[k-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_atomic_pad.sv
module gpio_atomic_pad #(
   parameter int PINS = 32
) (
   input  logic [PINS-1:0] out_val,
   input  logic [PINS-1:0] oe,
   input  logic [PINS-1:0] od,
   input  logic [PINS-1:0] pu,
   input  logic [PINS-1:0] pd,
   input  logic [PINS-1:0] ie,
   input  logic [PINS-1:0] sync_in,
   output logic [PINS-1:0] drv_en,
   output logic [PINS-1:0] drv_val,
   output logic [PINS-1:0] pu_en,
   output logic [PINS-1:0] pd_en,
   output logic [PINS-1:0] sample
);
   generate
      for (genvar p = 0; p < PINS; p++) begin : g_pin
         // open-drain: pull low for 0, release for 1
         assign drv_en[p]  = oe[p] & (~od[p] | ~out_val[p]);
         assign drv_val[p] = out_val[p] & ~od[p];
         assign pu_en[p]   = pu[p];
         assign pd_en[p]   = pd[p];
         assign sample[p]  = ie[p] & sync_in[p];
      end
   endgenerate

endmodule

// File: rtl/gpio_atomic_block.sv
module gpio_atomic_block
   import gpio_atomic_pkg::*;
#(
   parameter int PINS        = 32,
   parameter int BANK_W      = 16,
   parameter int ADDR_W      = 8,
   parameter int BANK_STRIDE = 128,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                wr_en,
   input  logic [2*BANK_W-1:0] wr_data,
   input  logic                rd_en,
   output logic [2*BANK_W-1:0] rd_data,
   input  logic [PINS-1:0]     pad_in,
   output logic [PINS-1:0]     pad_drv_en,
   output logic [PINS-1:0]     pad_drv_val,
   output logic [PINS-1:0]     pad_pu_en,
   output logic [PINS-1:0]     pad_pd_en,
   output logic [PINS-1:0]     in_sample
);
   localparam int NUM_BANKS = PINS / BANK_W;
   localparam int DATA_W    = 2 * BANK_W;

   generate
      if (PINS % BANK_W != 0)
         $error("pin count must be a whole number of banks");
      if (NUM_BANKS * BANK_STRIDE > (1 << ADDR_W))
         $error("banks do not fit in the address window");
      if ((BANK_STRIDE & (BANK_STRIDE - 1)) != 0)
         $error("bank stride must be a power of two");
   endgenerate

   logic [NUM_BANKS-1:0]                bank_hit;
   logic [NUM_FEAT-1:0]                 wr_sel;
   logic [NUM_FEAT-1:0]                 rd_sel;
   logic [NUM_FEAT-1:0][BANK_W-1:0]     bank_feat [NUM_BANKS];
   logic [NUM_FEAT-1:0][PINS-1:0]       pin_feat;
   logic [PINS-1:0]                     pad_sync;
   logic [BANK_W-1:0]                   rd_next;

   gpio_atomic_decode #(
      .ADDR_W(ADDR_W), .BANK_STRIDE(BANK_STRIDE), .NUM_BANKS(NUM_BANKS)
   ) u_decode (
      .addr(addr), .bank_hit(bank_hit), .wr_sel(wr_sel), .rd_sel(rd_sel)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         gpio_atomic_bank #(.BANK_W(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en & bank_hit[b]),
            .wr_sel   (wr_sel),
            .set_bits (wr_data[BANK_W-1:0]),
            .clr_bits (wr_data[DATA_W-1:BANK_W]),
            .feat_q   (bank_feat[b])
         );
         for (genvar f = 0; f < NUM_FEAT; f++) begin : g_flat
            assign pin_feat[f][b*BANK_W +: BANK_W] = bank_feat[b][f];
         end
      end
   endgenerate

   always_comb begin
      rd_next = '0;
      for (int b = 0; b < NUM_BANKS; b++)
         for (int f = 0; f < NUM_FEAT; f++)
            if (bank_hit[b] && rd_sel[f])
               rd_next = rd_next | bank_feat[b][f];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_en)
         rd_data <= {{BANK_W{1'b0}}, rd_next};
   end

   gpio_atomic_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
   );

   gpio_atomic_pad #(.PINS(PINS)) u_pad (
      .out_val (pin_feat[FI_OUT]),
      .oe      (pin_feat[FI_OE]),
      .od      (pin_feat[FI_OD]),
      .pu      (pin_feat[FI_PU]),
      .pd      (pin_feat[FI_PD]),
      .ie      (pin_feat[FI_IE]),
      .sync_in (pad_sync),
      .drv_en  (pad_drv_en),
      .drv_val (pad_drv_val),
      .pu_en   (pad_pu_en),
      .pd_en   (pad_pd_en),
      .sample  (in_sample)
   );

   AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[DATA_W-1:BANK_W] == '0); // R6
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data)); // R6
   AST_NO_DRIVE_WITHOUT_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_drv_en & ~pin_feat[FI_OE]) == '0); // R9
   AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_drv_val & pin_feat[FI_OD]) == '0); // R9
   AST_SAMPLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sample & ~pin_feat[FI_IE]) == '0); // R11

endmodule

// File: tb/sim_gpio_atomic_block.sv
`timescale 1ns/1ps
module sim_gpio_atomic_block;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_drv_en, pad_drv_val, pad_pu_en, pad_pd_en, in_sample;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   // model: m[feature][pin]; feature 0 out,1 oe,2 od,3 pu,4 pd,5 ie
   logic [31:0] m [6];

   always #10 clk = ~clk;

   gpio_atomic_block u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .pad_in(pad_in),
      .pad_drv_en(pad_drv_en), .pad_drv_val(pad_drv_val),
      .pad_pu_en(pad_pu_en), .pad_pd_en(pad_pd_en), .in_sample(in_sample)
   );

   function automatic int wr_idx(input logic [6:0] o);
      case (o)
         7'h00: return 0;
         7'h04: return 1;
         7'h08: return 2;
         7'h18: return 3;
         7'h1C: return 4;
         7'h20: return 5;
         default: return -1;
      endcase
   endfunction

   function automatic int rd_idx(input logic [6:0] o);
      if (o == 7'h30) return 0;
      if (o == 7'h00) return -1;
      return wr_idx(o);
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      int k;
      k = rd_idx(a[6:0]);
      if (k < 0) return 32'h0;
      return a[7] ? {16'h0, m[k][31:16]} : {16'h0, m[k][15:0]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_write(input logic [7:0] a, input logic [31:0] d);
      int k;
      k = wr_idx(a[6:0]);
      if (k >= 0)
         for (int i = 0; i < 16; i++) begin
            if (d[i+16]) m[k][a[7]*16+i] = 1'b0;
            else if (d[i]) m[k][a[7]*16+i] = 1'b1;
         end
   endtask

   task automatic do_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(a, d);
   endtask

   task automatic do_read(input logic [7:0] a, input string req);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check(req, rd_data, exp_read(a));
   endtask

   task automatic check_pads(input string tag);
      check({tag, " R9 drv_en"}, pad_drv_en, m[1] & (~m[2] | ~m[0]));
      check({tag, " R9 drv_val"}, pad_drv_val, m[0] & ~m[2]);
      check({tag, " R10 pu"}, pad_pu_en, m[3]);
      check({tag, " R10 pd"}, pad_pd_en, m[4]);
   endtask

   task automatic read_all(input string req);
      logic [7:0] regs [7] = '{8'h04, 8'h08, 8'h18, 8'h1C, 8'h20, 8'h30, 8'h00};
      for (int b = 0; b < 2; b++)
         for (int r = 0; r < 7; r++)
            do_read(regs[r] | 8'(b * 128), req);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] ofs_list [9] = '{8'h00, 8'h04, 8'h08, 8'h18, 8'h1C, 8'h20, 8'h30, 8'h0C, 8'h22};
      for (int k = 0; k < 6; k++) m[k] = '0;
      void'($urandom(32'h1234_5678));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 in_sample", in_sample, 32'h0);
      check("R1 rd_data", rd_data, 32'h0);
      check_pads("R1");
      read_all("R1 reset read");

      // R2 set only, low bank
      do_write(8'h04, 32'h0000_00A5);
      do_read(8'h04, "R2 set oe low");
      // R5 high bank independent
      do_read(8'h84, "R5 high bank untouched");
      do_write(8'h84, 32'h0000_0003);
      do_read(8'h84, "R5 set oe high");
      do_read(8'h04, "R5 low bank kept");
      // R3 clear and clear priority
      do_write(8'h04, 32'h0021_0001);
      do_read(8'h04, "R3 clear and both-bits");
      // R4 zero word / other registers unchanged
      do_write(8'h04, 32'h0000_0000);
      do_read(8'h04, "R4 zero word");
      do_read(8'h08, "R4 other feature");
      // R7 output level readback
      do_write(8'h00, 32'h0000_F00F);
      do_read(8'h30, "R7 readback");
      do_read(8'h00, "R7 write offset reads zero");
      do_write(8'h30, 32'h0000_FFFF);
      do_read(8'h30, "R7 write to readback ignored");
      // R8 unmapped offsets
      do_write(8'h0C, 32'hFFFF_FFFF);
      do_write(8'h40, 32'h0000_FFFF);
      do_write(8'h05, 32'h0000_FFFF);
      do_write(8'hFC, 32'h0000_FFFF);
      read_all("R8 unmapped write");
      do_read(8'h0C, "R8 unmapped read");
      do_read(8'h10, "R8 unmapped read");
      check_pads("R8");
      // R9 open-drain combinations
      do_write(8'h04, 32'h0000_FFFF);
      do_write(8'h08, 32'h0000_00F0);
      check_pads("R9 open-drain");
      do_write(8'h08, 32'h00FF_0000);
      check_pads("R9 push-pull");
      // R10 pulls
      do_write(8'h18, 32'h0000_1234);
      do_write(8'h9C, 32'h0000_8001);
      check_pads("R10 pulls");

      // R11 synchronizer and gating
      do_write(8'hA0, 32'h0000_FFFF);
      do_write(8'h20, 32'h0000_00FF);
      @(negedge clk);
      pad_in = 32'hFFFF_FFFF;
      @(negedge clk);
      check("R11 one edge", in_sample, 32'h0);
      @(negedge clk);
      check("R11 two edges", in_sample, 32'hFFFF_00FF);
      do_write(8'hA0, 32'h00F0_0000);
      check("R11 gated", in_sample, 32'hFF0F_00FF);
      pad_in = 32'h0;
      @(negedge clk);
      @(negedge clk);
      check("R11 falling", in_sample, 32'h0);

      // seeded random mix
      for (int n = 0; n < 300; n++) begin
         logic [7:0]  a;
         logic [31:0] d;
         a = ofs_list[$urandom % 9] | (($urandom % 2) != 0 ? 8'h80 : 8'h00);
         d = $urandom;
         if ((n % 4) == 0) d = d & 32'h0000_FFFF;
         if ((n % 4) == 1) d = d & 32'hFFFF_0000;
         do_write(a, d);
         check_pads("R9 R10 random");
         do_read(ofs_list[$urandom % 9] | (($urandom % 2) != 0 ? 8'h80 : 8'h00),
                 "R2 R3 R4 R6 random read");
      end
      read_all("R6 final read");

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule